// File: doc/BRIEF.md
# Reprogramming Watchdog Timer

This block is a safety timer placed around a change of clock frequency. Software arms it with a two-bit delay code, reprograms the frequency, checks that the system still works, and then disarms it. If the disarm write never arrives, the selected span runs out. The block then latches a sticky timeout flag. It can also send out a reset pulse of fixed length, and it can force the dynamic frequency selection back to its base code, which leaves dynamic frequency control turned off.

Time is measured in ticks of a slow timebase input. A parameter gives the number of ticks in half a second. The delay codes give one, two, four or eight of these half-second units. The span restarts from zero on every arming write, meaning a write that takes the enable from 0 to 1. The delay code is captured by that write only. The control register is written in a single cycle through a strobe. In that strobe cycle the tick input is not counted.

Top module: `reprog_watchdog`

## Requirements
- R1: After synchronous reset, timeout_flag, rst_pulse, dfc_revert and dfc_active are all 0.
- R2: After an arming write, timeout_flag rises in the cycle after the counted tick numbered HALF_TICKS << code, where code is the 2-bit delay select: 00 gives 0.5 s, 01 gives 1 s, 10 gives 2 s and 11 gives 4 s. It stays low after one tick fewer.
- R3: timeout_flag stays set until a write with the enable bit at 0. That write clears it. A write with the enable bit at 1 while the timer is already running neither clears the flag nor restarts the span.
- R4: If the enable is written to 0 before the span expires, no timeout occurs, and later ticks have no effect.
- R5: The delay code is taken only from the arming write. A code written while the timer is already enabled does not change the running span.
- R6: When the reset-output bit is set at timeout, rst_pulse goes high in the same cycle as the flag. It stays high for PULSE_TICKS further ticks (250 ms by default). When the bit is clear, rst_pulse stays low.
- R7: When the DFC-enable bit is set at timeout, dfc_revert is high for exactly one cycle, in the same cycle as the flag. It stays low when the bit is clear.
- R8: dfc_active shows the last written DFC-enable bit. A timeout clears it.
- R9: Only one timeout occurs per enable period. Further ticks produce no second pulse and no second revert strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase tick, one cycle wide |
| wr_en | input | 1 | Control register write strobe |
| wr_tmr_en | input | 1 | Timer enable bit of the write |
| wr_dly_sel | input | 2 | Delay code of the write |
| wr_rst_out_en | input | 1 | Reset-output enable bit of the write |
| wr_dfc_en | input | 1 | Dynamic frequency control enable bit of the write |
| timeout_flag | output | 1 | Sticky timeout flag |
| rst_pulse | output | 1 | Fixed-length reset pulse |
| dfc_revert | output | 1 | One-cycle strobe forcing frequency selection to base code 00 |
| dfc_active | output | 1 | Current dynamic frequency control enable |

## Verification
The hardest case to reach is a write that arrives while the timer is already running. It can re-enable the timer, change the delay code, or disarm the timer one tick before expiry, and each of these must leave the span alone or cancel it cleanly. The stimulus issues these writes directly: a mid-span code change, a repeated enable after a timeout, and random disarm points drawn below the span length for every code. After each of them the bench applies enough extra ticks to show whether a late flag, pulse or revert strobe appears.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef logic [1:0] dly_sel_t;

  // Span in ticks: half-second unit doubled per code step.
  function automatic int unsigned span_ticks(int unsigned half, dly_sel_t s);
    return half << s;
  endfunction
endpackage

// File: rtl/wdt_span_counter.sv
module wdt_span_counter #(
  parameter int unsigned HALF_TICKS = 500,
  parameter int unsigned CNT_W      = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                run,
  input  logic                tick,
  input  wdt_pkg::dly_sel_t   sel_i,
  output logic                expire_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             done;

  assign lim      = CNT_W'(wdt_pkg::span_ticks(HALF_TICKS, sel_i));
  assign expire_o = run && tick && !done && (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (restart) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (run && tick && !done) begin
      if (expire_o) done <= 1'b1;
      else          cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int unsigned PULSE_TICKS = 250,
  parameter int unsigned PW          = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic pulse_o
);
  logic [PW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      pc      <= '0;
    end else if (start) begin
      pulse_o <= 1'b1;
      pc      <= '0;
    end else if (pulse_o && tick) begin
      if (pc == PW'(PULSE_TICKS - 1)) pulse_o <= 1'b0;
      else                            pc      <= pc + 1'b1;
    end
  end
endmodule

// File: rtl/reprog_watchdog.sv
module reprog_watchdog #(
  parameter int unsigned HALF_TICKS  = 500,
  parameter int unsigned PULSE_TICKS = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic       wr_tmr_en,
  input  logic [1:0] wr_dly_sel,
  input  logic       wr_rst_out_en,
  input  logic       wr_dfc_en,
  output logic       timeout_flag,
  output logic       rst_pulse,
  output logic       dfc_revert,
  output logic       dfc_active
);
  localparam int unsigned CNT_W = $clog2(HALF_TICKS * 8 + 1);
  localparam int unsigned PW    = $clog2(PULSE_TICKS + 1);

  logic              en_q;
  logic              roe_q;
  wdt_pkg::dly_sel_t sel_q;
  logic              restart;
  logic              run;
  logic              expire;

  assign restart = wr_en && wr_tmr_en && !en_q;
  assign run     = en_q && !wr_en;

  wdt_span_counter #(.HALF_TICKS(HALF_TICKS), .CNT_W(CNT_W)) u_span (
    .clk(clk), .rst(rst), .restart(restart), .run(run),
    .tick(tick), .sel_i(sel_q), .expire_o(expire)
  );

  wdt_pulse_gen #(.PULSE_TICKS(PULSE_TICKS), .PW(PW)) u_pulse (
    .clk(clk), .rst(rst), .start(expire && roe_q),
    .tick(tick), .pulse_o(rst_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q         <= 1'b0;
      roe_q        <= 1'b0;
      sel_q        <= '0;
      dfc_active   <= 1'b0;
      timeout_flag <= 1'b0;
      dfc_revert   <= 1'b0;
    end else begin
      dfc_revert <= 1'b0;
      if (wr_en) begin
        en_q       <= wr_tmr_en;
        roe_q      <= wr_rst_out_en;
        dfc_active <= wr_dfc_en;
        if (restart)    sel_q        <= wr_dly_sel;
        if (!wr_tmr_en) timeout_flag <= 1'b0;
      end else if (expire) begin
        timeout_flag <= 1'b1;
        if (dfc_active) begin
          dfc_revert <= 1'b1;
          dfc_active <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic wr_tmr_en,
  input logic en_q,
  input logic timeout_flag,
  input logic rst_pulse,
  input logic dfc_revert,
  input logic dfc_active
);
  p_flag_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_flag) |-> en_q);

  p_flag_cleared_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_tmr_en) |=> !timeout_flag);

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (timeout_flag && !(wr_en && !wr_tmr_en)) |=> timeout_flag);

  p_pulse_with_flag_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pulse) |-> $rose(timeout_flag));

  p_revert_single_r7: assert property (@(posedge clk) disable iff (rst)
    dfc_revert |=> !dfc_revert);

  p_revert_with_flag_r7: assert property (@(posedge clk) disable iff (rst)
    dfc_revert |-> $rose(timeout_flag));

  p_revert_disables_r8: assert property (@(posedge clk) disable iff (rst)
    dfc_revert |-> !dfc_active);
endmodule

bind reprog_watchdog wdt_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tmr_en(wr_tmr_en), .en_q(en_q),
  .timeout_flag(timeout_flag), .rst_pulse(rst_pulse),
  .dfc_revert(dfc_revert), .dfc_active(dfc_active)
);

// File: tb/reprog_watchdog_tb.sv
module reprog_watchdog_tb;
  localparam int unsigned HALF  = 4;
  localparam int unsigned PULSE = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0, wr_tmr_en = 1'b0, wr_rst_out_en = 1'b0, wr_dfc_en = 1'b0;
  logic [1:0] wr_dly_sel = 2'b00;
  logic timeout_flag, rst_pulse, dfc_revert, dfc_active;

  int checks = 0;
  int failures = 0;
  int rev_cnt = 0;
  int pulse_rises = 0;
  bit finished = 1'b0;
  logic prev_p = 1'b0;

  always #10 clk = ~clk;

  reprog_watchdog #(.HALF_TICKS(HALF), .PULSE_TICKS(PULSE)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_tmr_en(wr_tmr_en),
    .wr_dly_sel(wr_dly_sel), .wr_rst_out_en(wr_rst_out_en), .wr_dfc_en(wr_dfc_en),
    .timeout_flag(timeout_flag), .rst_pulse(rst_pulse),
    .dfc_revert(dfc_revert), .dfc_active(dfc_active)
  );

  always @(negedge clk) begin
    if (dfc_revert) rev_cnt++;
    if (rst_pulse && !prev_p) pulse_rises++;
    prev_p = rst_pulse;
  end

  function automatic int unsigned span(logic [1:0] s);
    return HALF << s;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic en, logic [1:0] s, logic roe, logic dfc);
    wr_en = 1'b1; wr_tmr_en = en; wr_dly_sel = s;
    wr_rst_out_en = roe; wr_dfc_en = dfc;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 flag", timeout_flag, 0);
    chk("R1 pulse", rst_pulse, 0);
    chk("R1 revert", dfc_revert, 0);
    chk("R1 dfc", dfc_active, 0);

    // Directed: each delay code, with reset-output and DFC bits mixed.
    for (int s = 0; s < 4; s++) begin
      logic roe, dfc;
      int r0, p0;
      roe = s[0]; dfc = s[1];
      wr(1'b1, 2'(s), roe, dfc);
      chk("R8 dfc follows write", dfc_active, int'(dfc));
      ticks(span(2'(s)) - 1);
      chk("R2 no flag one tick early", timeout_flag, 0);
      ticks(1);
      chk("R2 flag at span", timeout_flag, 1);
      chk("R6 pulse matches bit", rst_pulse, int'(roe));
      chk("R7 revert matches bit", dfc_revert, int'(dfc));
      chk("R8 dfc cleared by timeout", dfc_active, 0);
      @(negedge clk);
      chk("R7 revert one cycle", dfc_revert, 0);
      if (roe) begin
        ticks(PULSE - 1);
        chk("R6 pulse still high", rst_pulse, 1);
        ticks(1);
        chk("R6 pulse ended", rst_pulse, 0);
      end
      r0 = rev_cnt; p0 = pulse_rises;
      ticks(2 * span(2'(s)));
      chk("R9 no second revert", rev_cnt, r0);
      chk("R9 no second pulse", pulse_rises, p0);
      chk("R3 flag sticky", timeout_flag, 1);
      wr(1'b1, 2'(s), roe, 1'b0);
      chk("R3 enable rewrite keeps flag", timeout_flag, 1);
      ticks(span(2'(s)) + 2);
      chk("R3 rewrite no restart", pulse_rises, p0);
      wr(1'b0, 2'b00, 1'b0, 1'b0);
      chk("R3 flag cleared", timeout_flag, 0);
    end

    // Code written while running is ignored.
    wr(1'b1, 2'b00, 1'b1, 1'b0);
    wr(1'b1, 2'b11, 1'b1, 1'b0);
    ticks(HALF - 1);
    chk("R5 no flag early", timeout_flag, 0);
    ticks(1);
    chk("R5 original span kept", timeout_flag, 1);
    ticks(PULSE);
    wr(1'b0, 2'b00, 1'b0, 1'b0);

    // Random arming, with early disarm or full expiry.
    for (int it = 0; it < 24; it++) begin
      logic [1:0] s;
      logic roe, dfc;
      int k, r0, p0;
      s = 2'($urandom_range(3, 0));
      roe = 1'($urandom_range(1, 0));
      dfc = 1'($urandom_range(1, 0));
      wr(1'b1, s, roe, dfc);
      if ($urandom_range(1, 0) == 1) begin
        k = int'($urandom_range(span(s) - 1, 0));
        ticks(k);
        r0 = rev_cnt; p0 = pulse_rises;
        wr(1'b0, s, roe, dfc);
        ticks(span(s) + 1);
        chk("R4 no flag after disarm", timeout_flag, 0);
        chk("R4 no pulse after disarm", pulse_rises, p0);
        chk("R4 no revert after disarm", rev_cnt, r0);
        chk("R8 dfc kept", dfc_active, int'(dfc));
      end else begin
        r0 = rev_cnt; p0 = pulse_rises;
        ticks(span(s) - 1);
        chk("R2 random early", timeout_flag, 0);
        ticks(1);
        chk("R2 random flag", timeout_flag, 1);
        ticks(PULSE + 1);
        chk("R6 random pulse count", pulse_rises, p0 + int'(roe));
        chk("R7 random revert count", rev_cnt, r0 + int'(dfc));
        wr(1'b0, 2'b00, 1'b0, 1'b0);
        chk("R3 random clear", timeout_flag, 0);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule